// File: doc/BRIEF.md
# Network packet tag insert and check unit

This unit sits between a processing element and its network router and defends against a router that quietly rewrites packet addresses. On the way out it binds the source and destination addresses into a 12-bit tag and hides that tag inside the payload. It then scrambles the mixed field with a key that changes from packet to packet, and stamps the key's 8-bit selector label into fixed hidden bit slots. On the way in it undoes every step and recomputes the tag from the addresses the packet actually carries. It delivers the payload only when the two tags agree.

The per-packet label comes from an internal 16-bit linear feedback shift register. A small key generator expands it into a 20-bit key by picking and reordering 4-bit words from a 16-word constant table. The upper 12 key bits mask the tag. The lower 8 bits steer a bank of small block rotators. Both directions use valid/ready handshakes, and each result sits in an output register for one cycle.

Top module: `pkt_tag_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after it, tx_out_valid, rx_out_valid and hijack_detected are 0, and tx_in_ready and rx_in_ready are 1.
- R2: An outgoing packet accepted on a clock edge appears on tx_out_pkt with tx_out_valid high after that edge. tx_out_pkt[127:122] is the source, [121:116] is the destination, and [115:0] is the body.
- R3: The label is bits [7:0] of a 16-bit register seeded with 0xACE1. Each step shifts it left and feeds back bit15^bit13^bit12^bit10 into bit 0. It steps once per accepted outgoing packet and never otherwise.
- R4: Key table word i (i = 0..15) is bits [4i+3:4i] of 0x7E3A9C150F84D26B. Pick k (k = 0..4) is word 2k+label[k]. s[j] = pick[j XOR label[6:5]] for j = 0..3, and G = {s3,s2,s1,s0}. The key is {G,pick4} when label[7] is 1, else {pick4,G}. The tag mask is key[19:8] and the rotation key is key[7:0].
- R5: The tag is {src,dst} XOR key[19:8]. Tag bit k sits at field position (9k+5) mod 108. The 96 payload bits fill the other field positions in ascending order.
- R6: The 108-bit field is cut from bit 0 into 8-bit blocks; block 13 is 4 bits wide. Block b is rotated toward its MSB by c mod its width. Bit i of the 3-bit c is rotation-key bit (b/2 + i) mod 8.
- R7: Label bit k sits at body position (13k+3) mod 116. The scrambled field fills the other body positions in ascending order.
- R8: An incoming packet whose recomputed tag matches its hidden tag raises rx_out_valid after the accepting edge. rx_out_payload and rx_out_src then carry its payload and source, and hijack_detected stays 0.
- R9: An incoming packet whose tags differ is not delivered. hijack_detected is high for exactly the one cycle after the accepting edge, and rx_out_valid is low in that cycle.
- R10: Each in_ready equals !out_valid || out_ready. While an output is valid and not taken, its contents stay unchanged and no input is accepted.
- R11: Altering the source or destination bits of a correctly tagged packet while leaving its body intact always causes a drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Outgoing request valid |
| tx_in_ready | output | 1 | Outgoing request accepted when high with valid |
| tx_src | input | 6 | Source node address |
| tx_dst | input | 6 | Destination node address |
| tx_payload | input | 96 | Payload to protect |
| tx_out_valid | output | 1 | Tagged packet valid |
| tx_out_ready | input | 1 | Router takes the tagged packet |
| tx_out_pkt | output | 128 | Tagged packet |
| rx_in_valid | input | 1 | Incoming packet valid |
| rx_in_ready | output | 1 | Incoming packet accepted when high with valid |
| rx_pkt | input | 128 | Incoming packet |
| rx_out_valid | output | 1 | Authenticated payload valid |
| rx_out_ready | input | 1 | Processing element takes the payload |
| rx_out_src | output | 6 | Source of the authenticated packet |
| rx_out_payload | output | 96 | Authenticated payload |
| hijack_detected | output | 1 | One-cycle pulse per dropped packet |

## Verification
The handshake assertions assume that no consumer withdraws a taken output. They also assume that no producer relies on an input being seen before ready is high. The stimulus changes inputs only at falling edges and keeps each request asserted until its accepting edge. The address-tamper checks flip exactly one address bit of a packet the unit itself produced, so a drop is guaranteed. The label-tamper checks rely on the bench's own decoder to say whether that particular corruption happens to survive.

// File: rtl/pkt_tag_pkg.sv
package pkt_tag_pkg;
  // 16 distinct 4-bit words forming the key expansion table
  localparam logic [63:0] KEY_WORDS_DEFAULT = 64'h7E3A9C150F84D26B;
  localparam logic [15:0] LFSR_SEED_DEFAULT = 16'hACE1;
  localparam logic [15:0] LFSR_TAPS_DEFAULT = 16'hB400;

  typedef enum logic {ROT_FWD = 1'b0, ROT_INV = 1'b1} rot_dir_e;
endpackage

// File: rtl/pkt_tag_lfsr.sv
module pkt_tag_lfsr #(
  parameter int          W     = 16,
  parameter int          OUT_W = 8,
  parameter logic [15:0] TAPS  = pkt_tag_pkg::LFSR_TAPS_DEFAULT,
  parameter logic [15:0] SEED  = pkt_tag_pkg::LFSR_SEED_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [OUT_W-1:0] label
);
  logic [W-1:0] state;
  logic         fb;

  assign fb    = ^(state & TAPS[W-1:0]);
  assign label = state[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED[W-1:0];
    else if (step) state <= {state[W-2:0], fb};
  end

  assert_lfsr_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  assert_lfsr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> state != $past(state));
  assert_lfsr_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/pkt_tag_keygen.sv
module pkt_tag_keygen #(
  parameter int          WORD_W = 4,
  parameter int          N_PICK = 5,
  parameter logic [63:0] WORDS  = pkt_tag_pkg::KEY_WORDS_DEFAULT,
  localparam int         LBL_W  = N_PICK + 3,
  localparam int         KEY_W  = N_PICK * WORD_W
) (
  input  logic [LBL_W-1:0] label,
  output logic [KEY_W-1:0] key
);
  localparam int GRP_N  = 4;
  localparam int GRP_W  = GRP_N * WORD_W;
  localparam int REST_N = N_PICK - GRP_N;
  localparam int REST_W = REST_N * WORD_W;

  logic [WORD_W-1:0] pick [N_PICK];
  logic [WORD_W-1:0] shuf [GRP_N];
  logic [GRP_W-1:0]  grp;
  logic [REST_W-1:0] rest;

  always_comb begin
    for (int k = 0; k < N_PICK; k++)
      pick[k] = WORDS[(2*k + int'(label[k]))*WORD_W +: WORD_W];
    for (int j = 0; j < GRP_N; j++)
      shuf[j] = pick[j ^ int'(label[N_PICK +: 2])];
    for (int j = 0; j < GRP_N; j++)
      grp[j*WORD_W +: WORD_W] = shuf[j];
    for (int r = 0; r < REST_N; r++)
      rest[r*WORD_W +: WORD_W] = pick[GRP_N + r];
    key = label[N_PICK+2] ? {grp, rest} : {rest, grp};
  end
endmodule

// File: rtl/pkt_tag_rotator.sv
module pkt_tag_rotator #(
  parameter int                   FIELD_W     = 108,
  parameter int                   BLK_W       = 8,
  parameter int                   KS_W        = 8,
  parameter int                   BLK_PER_GRP = 2,
  parameter pkt_tag_pkg::rot_dir_e DIR        = pkt_tag_pkg::ROT_FWD
) (
  input  logic [FIELD_W-1:0] din,
  input  logic [KS_W-1:0]    ks,
  output logic [FIELD_W-1:0] dout
);
  localparam int N_BLK  = (FIELD_W + BLK_W - 1) / BLK_W;
  localparam int LAST_W = FIELD_W - (N_BLK - 1) * BLK_W;
  localparam int SH_W   = $clog2(BLK_W);

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    localparam int W = (b == N_BLK - 1) ? LAST_W : BLK_W;
    localparam int G = b / BLK_PER_GRP;
    logic [SH_W-1:0] ctl;
    logic [W-1:0]    bin;
    logic [W-1:0]    bout;

    for (genvar i = 0; i < SH_W; i++) begin : g_ctl
      assign ctl[i] = ks[(G + i) % KS_W];
    end

    assign bin = din[b*BLK_W +: W];

    always_comb begin
      for (int i = 0; i < W; i++) begin
        if (DIR == pkt_tag_pkg::ROT_INV)
          bout[i] = bin[(i + int'(ctl) % W) % W];
        else
          bout[i] = bin[(i - int'(ctl) % W + W) % W];
      end
    end

    assign dout[b*BLK_W +: W] = bout;
  end
endmodule

// File: rtl/pkt_tag_unit.sv
module pkt_tag_unit #(
  parameter int          ADDR_W     = 6,
  parameter int          PAY_W      = 96,
  parameter int          LBL_W      = 8,
  parameter int          BLK_W      = 8,
  parameter int          TAG_STRIDE = 9,
  parameter int          TAG_OFS    = 5,
  parameter int          LBL_STRIDE = 13,
  parameter int          LBL_OFS    = 3,
  parameter int          LFSR_W     = 16,
  parameter logic [63:0] KEY_WORDS  = pkt_tag_pkg::KEY_WORDS_DEFAULT
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              tx_in_valid,
  output logic                              tx_in_ready,
  input  logic [ADDR_W-1:0]                 tx_src,
  input  logic [ADDR_W-1:0]                 tx_dst,
  input  logic [PAY_W-1:0]                  tx_payload,
  output logic                              tx_out_valid,
  input  logic                              tx_out_ready,
  output logic [4*ADDR_W+PAY_W+LBL_W-1:0]   tx_out_pkt,
  input  logic                              rx_in_valid,
  output logic                              rx_in_ready,
  input  logic [4*ADDR_W+PAY_W+LBL_W-1:0]   rx_pkt,
  output logic                              rx_out_valid,
  input  logic                              rx_out_ready,
  output logic [ADDR_W-1:0]                 rx_out_src,
  output logic [PAY_W-1:0]                  rx_out_payload,
  output logic                              hijack_detected
);
  localparam int TAG_W   = 2 * ADDR_W;
  localparam int FIELD_W = PAY_W + TAG_W;
  localparam int BODY_W  = FIELD_W + LBL_W;
  localparam int PKT_W   = BODY_W + TAG_W;
  localparam int KEY_W   = TAG_W + LBL_W;
  localparam int KS_W    = LBL_W;
  localparam int N_PICK  = LBL_W - 3;

  // ---- secret slot maps -------------------------------------------------
  function automatic int tag_slot(int p);
    for (int k = 0; k < TAG_W; k++)
      if ((k*TAG_STRIDE + TAG_OFS) % FIELD_W == p) return k;
    return -1;
  endfunction

  function automatic int lbl_slot(int p);
    for (int k = 0; k < LBL_W; k++)
      if ((k*LBL_STRIDE + LBL_OFS) % BODY_W == p) return k;
    return -1;
  endfunction

  function automatic logic [FIELD_W-1:0] merge_tag(input logic [PAY_W-1:0] pay,
                                                   input logic [TAG_W-1:0] tag);
    logic [FIELD_W-1:0] f;
    int n;
    int s;
    f = '0;
    n = 0;
    for (int p = 0; p < FIELD_W; p++) begin
      s = tag_slot(p);
      if (s >= 0) f[p] = tag[s];
      else begin
        if (n < PAY_W) f[p] = pay[n];
        n++;
      end
    end
    return f;
  endfunction

  function automatic logic [TAG_W-1:0] pull_tag(input logic [FIELD_W-1:0] f);
    logic [TAG_W-1:0] t;
    for (int k = 0; k < TAG_W; k++) t[k] = f[(k*TAG_STRIDE + TAG_OFS) % FIELD_W];
    return t;
  endfunction

  function automatic logic [PAY_W-1:0] pull_pay(input logic [FIELD_W-1:0] f);
    logic [PAY_W-1:0] d;
    int n;
    d = '0;
    n = 0;
    for (int p = 0; p < FIELD_W; p++) begin
      if (tag_slot(p) < 0) begin
        if (n < PAY_W) d[n] = f[p];
        n++;
      end
    end
    return d;
  endfunction

  function automatic logic [BODY_W-1:0] merge_label(input logic [FIELD_W-1:0] f,
                                                    input logic [LBL_W-1:0] l);
    logic [BODY_W-1:0] b;
    int n;
    int s;
    b = '0;
    n = 0;
    for (int p = 0; p < BODY_W; p++) begin
      s = lbl_slot(p);
      if (s >= 0) b[p] = l[s];
      else begin
        if (n < FIELD_W) b[p] = f[n];
        n++;
      end
    end
    return b;
  endfunction

  function automatic logic [LBL_W-1:0] pull_label(input logic [BODY_W-1:0] b);
    logic [LBL_W-1:0] l;
    for (int k = 0; k < LBL_W; k++) l[k] = b[(k*LBL_STRIDE + LBL_OFS) % BODY_W];
    return l;
  endfunction

  function automatic logic [FIELD_W-1:0] pull_field(input logic [BODY_W-1:0] b);
    logic [FIELD_W-1:0] f;
    int n;
    f = '0;
    n = 0;
    for (int p = 0; p < BODY_W; p++) begin
      if (lbl_slot(p) < 0) begin
        if (n < FIELD_W) f[n] = b[p];
        n++;
      end
    end
    return f;
  endfunction

  // ---- transmit path ----------------------------------------------------
  logic               tx_fire;
  logic [LBL_W-1:0]   tx_label;
  logic [KEY_W-1:0]   tx_key;
  logic [TAG_W-1:0]   tx_tag;
  logic [FIELD_W-1:0] tx_field;
  logic [FIELD_W-1:0] tx_scr;
  logic [BODY_W-1:0]  tx_body;

  assign tx_in_ready = !tx_out_valid || tx_out_ready;
  assign tx_fire     = tx_in_valid && tx_in_ready;

  pkt_tag_lfsr #(.W(LFSR_W), .OUT_W(LBL_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(tx_fire), .label(tx_label)
  );

  pkt_tag_keygen #(.WORD_W(KEY_W / N_PICK), .N_PICK(N_PICK), .WORDS(KEY_WORDS)) u_kg_tx (
    .label(tx_label), .key(tx_key)
  );

  assign tx_tag   = {tx_src, tx_dst} ^ tx_key[KEY_W-1 -: TAG_W];
  assign tx_field = merge_tag(tx_payload, tx_tag);

  pkt_tag_rotator #(.FIELD_W(FIELD_W), .BLK_W(BLK_W), .KS_W(KS_W),
                    .DIR(pkt_tag_pkg::ROT_FWD)) u_rot_tx (
    .din(tx_field), .ks(tx_key[KS_W-1:0]), .dout(tx_scr)
  );

  assign tx_body = merge_label(tx_scr, tx_label);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_out_valid <= 1'b0;
      tx_out_pkt   <= '0;
    end else if (tx_fire) begin
      tx_out_valid <= 1'b1;
      tx_out_pkt   <= {tx_src, tx_dst, tx_body};
    end else if (tx_out_ready) begin
      tx_out_valid <= 1'b0;
    end
  end

  // ---- receive path -----------------------------------------------------
  logic               rx_fire;
  logic [ADDR_W-1:0]  rx_src_f;
  logic [ADDR_W-1:0]  rx_dst_f;
  logic [LBL_W-1:0]   rx_label;
  logic [KEY_W-1:0]   rx_key;
  logic [FIELD_W-1:0] rx_scr;
  logic [FIELD_W-1:0] rx_field;
  logic [TAG_W-1:0]   rx_tag_rcv;
  logic [TAG_W-1:0]   rx_tag_calc;
  logic               rx_match;

  assign rx_in_ready = !rx_out_valid || rx_out_ready;
  assign rx_fire     = rx_in_valid && rx_in_ready;
  assign rx_src_f    = rx_pkt[PKT_W-1 -: ADDR_W];
  assign rx_dst_f    = rx_pkt[PKT_W-ADDR_W-1 -: ADDR_W];
  assign rx_label    = pull_label(rx_pkt[BODY_W-1:0]);
  assign rx_scr      = pull_field(rx_pkt[BODY_W-1:0]);

  pkt_tag_keygen #(.WORD_W(KEY_W / N_PICK), .N_PICK(N_PICK), .WORDS(KEY_WORDS)) u_kg_rx (
    .label(rx_label), .key(rx_key)
  );

  pkt_tag_rotator #(.FIELD_W(FIELD_W), .BLK_W(BLK_W), .KS_W(KS_W),
                    .DIR(pkt_tag_pkg::ROT_INV)) u_rot_rx (
    .din(rx_scr), .ks(rx_key[KS_W-1:0]), .dout(rx_field)
  );

  assign rx_tag_rcv  = pull_tag(rx_field);
  assign rx_tag_calc = {rx_src_f, rx_dst_f} ^ rx_key[KEY_W-1 -: TAG_W];
  assign rx_match    = (rx_tag_rcv == rx_tag_calc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_out_valid    <= 1'b0;
      rx_out_src      <= '0;
      rx_out_payload  <= '0;
      hijack_detected <= 1'b0;
    end else if (rx_fire) begin
      rx_out_valid    <= rx_match;
      hijack_detected <= !rx_match;
      if (rx_match) begin
        rx_out_src     <= rx_src_f;
        rx_out_payload <= pull_pay(rx_field);
      end
    end else begin
      hijack_detected <= 1'b0;
      if (rx_out_ready) rx_out_valid <= 1'b0;
    end
  end

  // ---- assertions -------------------------------------------------------
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_pkt));
  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_payload) && $stable(rx_out_src));
  assert_tx_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> tx_out_pkt[PKT_W-1 -: TAG_W] == $past({tx_src, tx_dst}));
  assert_scramble_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_in_valid |-> $countones(tx_scr) == $countones(tx_field));
  assert_unscramble_weight_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid |-> $countones(rx_field) == $countones(rx_scr));
  assert_drop_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hijack_detected |-> $past(rx_in_valid && rx_in_ready));
  assert_no_deliver_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hijack_detected |-> !rx_out_valid);
endmodule

// File: tb/pkt_tag_unit_tb.sv
module pkt_tag_unit_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic [5:0]   tx_src, tx_dst;
  logic [95:0]  tx_payload;
  logic [127:0] tx_out_pkt;
  logic         rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready;
  logic [127:0] rx_pkt;
  logic [5:0]   rx_out_src;
  logic [95:0]  rx_out_payload;
  logic         hijack_detected;

  pkt_tag_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_src(tx_src), .tx_dst(tx_dst), .tx_payload(tx_payload),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_pkt(tx_out_pkt),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_pkt(rx_pkt),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready),
    .rx_out_src(rx_out_src), .rx_out_payload(rx_out_payload),
    .hijack_detected(hijack_detected)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [15:0] m_lfsr;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---- reference model ----
  function automatic logic [15:0] lfsr_adv(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [19:0] ref_key(input logic [7:0] l);
    logic [63:0] tbl;
    logic [3:0]  w [5];
    logic [3:0]  s [4];
    logic [15:0] g;
    tbl = 64'h7E3A9C150F84D26B;
    for (int k = 0; k < 5; k++) w[k] = tbl[4*(2*k + int'(l[k])) +: 4];
    for (int j = 0; j < 4; j++) s[j] = w[j ^ int'(l[6:5])];
    g = {s[3], s[2], s[1], s[0]};
    return l[7] ? {g, w[4]} : {w[4], g};
  endfunction

  function automatic logic [107:0] ref_rot(input logic [107:0] f, input logic [7:0] ks, input bit inv);
    logic [107:0] o;
    o = '0;
    for (int p = 0; p < 108; p++) begin
      int b, w, g, a, off;
      b = p / 8;
      w = (b == 13) ? 4 : 8;
      g = b / 2;
      a = (int'(ks[g % 8]) + 2*int'(ks[(g+1) % 8]) + 4*int'(ks[(g+2) % 8])) % w;
      off = p - b*8;
      if (!inv) o[b*8 + (off + a) % w] = f[p];
      else      o[b*8 + (off - a + w) % w] = f[p];
    end
    return o;
  endfunction

  function automatic logic [127:0] ref_encode(input logic [5:0] s, input logic [5:0] d,
                                              input logic [95:0] pay, input logic [7:0] l);
    logic [19:0]  key;
    logic [11:0]  tag;
    logic [107:0] fld, scr;
    logic [115:0] body;
    bit used [116];
    int n;
    key = ref_key(l);
    tag = {s, d} ^ key[19:8];
    fld = '0;
    for (int p = 0; p < 116; p++) used[p] = 1'b0;
    for (int k = 0; k < 12; k++) begin fld[(9*k+5) % 108] = tag[k]; used[(9*k+5) % 108] = 1'b1; end
    n = 0;
    for (int p = 0; p < 108; p++) if (!used[p]) begin fld[p] = pay[n]; n++; end
    scr = ref_rot(fld, key[7:0], 1'b0);
    for (int p = 0; p < 116; p++) used[p] = 1'b0;
    body = '0;
    for (int k = 0; k < 8; k++) begin body[(13*k+3) % 116] = l[k]; used[(13*k+3) % 116] = 1'b1; end
    n = 0;
    for (int p = 0; p < 116; p++) if (!used[p]) begin body[p] = scr[n]; n++; end
    return {s, d, body};
  endfunction

  task automatic ref_decode(input logic [127:0] pk, output bit ok, output logic [95:0] pay);
    logic [7:0]   l;
    logic [19:0]  key;
    logic [107:0] scr, fld;
    logic [11:0]  tag;
    bit used [116];
    int n;
    for (int p = 0; p < 116; p++) used[p] = 1'b0;
    for (int k = 0; k < 8; k++) begin l[k] = pk[(13*k+3) % 116]; used[(13*k+3) % 116] = 1'b1; end
    n = 0;
    scr = '0;
    for (int p = 0; p < 116; p++) if (!used[p]) begin scr[n] = pk[p]; n++; end
    key = ref_key(l);
    fld = ref_rot(scr, key[7:0], 1'b1);
    for (int p = 0; p < 116; p++) used[p] = 1'b0;
    for (int k = 0; k < 12; k++) begin tag[k] = fld[(9*k+5) % 108]; used[(9*k+5) % 108] = 1'b1; end
    n = 0;
    pay = '0;
    for (int p = 0; p < 108; p++) if (!used[p]) begin pay[n] = fld[p]; n++; end
    ok = (tag == ({pk[127:122], pk[121:116]} ^ key[19:8]));
  endtask

  // ---- drivers ----
  task automatic send_tx(input logic [5:0] s, input logic [5:0] d, input logic [95:0] pay,
                         output logic v, output logic [127:0] pk);
    @(negedge clk);
    tx_src = s; tx_dst = d; tx_payload = pay; tx_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v = tx_out_valid; pk = tx_out_pkt;
    tx_in_valid = 1'b0;
  endtask

  task automatic send_rx(input logic [127:0] pk, output logic v, output logic h,
                         output logic [95:0] pay, output logic [5:0] s);
    @(negedge clk);
    rx_pkt = pk; rx_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    v = rx_out_valid; h = hijack_detected; pay = rx_out_payload; s = rx_out_src;
    rx_in_valid = 1'b0;
  endtask

  task automatic run_case(input logic [5:0] s, input logic [5:0] d, input logic [95:0] pay);
    logic [127:0] exp_pk, pk, bad;
    logic v, h;
    logic [95:0] rp;
    logic [5:0]  rs;
    bit ok;
    logic [95:0] mp;
    int k;
    exp_pk = ref_encode(s, d, pay, m_lfsr[7:0]);
    send_tx(s, d, pay, v, pk);
    m_lfsr = lfsr_adv(m_lfsr);
    check(v == 1'b1, "R2", "tx_out_valid", 128'(v), 128'(1));
    check(pk == exp_pk, "R3/R4/R5/R6/R7", "tx packet", pk, exp_pk);
    send_rx(pk, v, h, rp, rs);
    check(v == 1'b1 && h == 1'b0, "R8", "deliver flags", 128'({v, h}), 128'(2'b10));
    check(rp == pay && rs == s, "R8", "delivered payload/src", 128'({rs, rp}), 128'({s, pay}));
    // source tamper
    k = $urandom_range(0, 5);
    bad = pk ^ (128'd1 << (122 + k));
    send_rx(bad, v, h, rp, rs);
    check(v == 1'b0 && h == 1'b1, "R11 R9", "src tamper flags", 128'({v, h}), 128'(2'b01));
    @(negedge clk);
    check(hijack_detected == 1'b0, "R9", "pulse width", 128'(hijack_detected), 128'(0));
    // destination tamper
    k = $urandom_range(0, 5);
    bad = pk ^ (128'd1 << (116 + k));
    send_rx(bad, v, h, rp, rs);
    check(v == 1'b0 && h == 1'b1, "R11 R9", "dst tamper flags", 128'({v, h}), 128'(2'b01));
    // label tamper
    k = $urandom_range(0, 7);
    bad = pk ^ (128'd1 << ((13*k + 3) % 116));
    ref_decode(bad, ok, mp);
    send_rx(bad, v, h, rp, rs);
    check(v == ok && h == !ok, "R8/R9", "label tamper flags", 128'({v, h}), 128'({ok, !ok}));
    if (ok) check(rp == mp, "R8", "label tamper payload", 128'(rp), 128'(mp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [127:0] p1, p2, e1, e2, good, bad;
    logic v, h;
    logic [95:0] rp;
    logic [5:0]  rs;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    tx_out_ready = 1'b1; rx_out_ready = 1'b1;
    tx_src = '0; tx_dst = '0; tx_payload = '0; rx_pkt = '0;
    m_lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    check({tx_out_valid, rx_out_valid, hijack_detected} == 3'b000, "R1", "reset valids",
          128'({tx_out_valid, rx_out_valid, hijack_detected}), 128'(0));
    check(tx_in_ready && rx_in_ready, "R1", "reset readies", 128'({tx_in_ready, rx_in_ready}), 128'(3));
    rst_n = 1'b1;
    @(negedge clk);
    check(!tx_out_valid && !rx_out_valid && !hijack_detected, "R1", "after release",
          128'({tx_out_valid, rx_out_valid, hijack_detected}), 128'(0));

    // directed corners
    run_case(6'd0, 6'd0, '0);
    run_case(6'h3F, 6'h3F, '1);
    run_case(6'h3F, 6'd0, 96'hA5A5_A5A5_5A5A_5A5A_F0F0_0F0F);
    run_case(6'd0, 6'h3F, 96'h1);

    // random traffic
    for (int i = 0; i < 40; i++)
      run_case(6'($urandom), 6'($urandom), {$urandom, $urandom, $urandom});

    // transmit stall
    e1 = ref_encode(6'd5, 6'd9, 96'hDEAD, m_lfsr[7:0]);
    @(negedge clk);
    tx_out_ready = 1'b0;
    tx_src = 6'd5; tx_dst = 6'd9; tx_payload = 96'hDEAD; tx_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_lfsr = lfsr_adv(m_lfsr);
    check(tx_out_valid && tx_out_pkt == e1, "R10", "stalled tx first", tx_out_pkt, e1);
    check(tx_in_ready == 1'b0, "R10", "tx_in_ready stalled", 128'(tx_in_ready), 128'(0));
    tx_src = 6'd7; tx_dst = 6'd2; tx_payload = 96'hBEEF;
    e2 = ref_encode(6'd7, 6'd2, 96'hBEEF, m_lfsr[7:0]);
    repeat (2) @(negedge clk);
    check(tx_out_valid && tx_out_pkt == e1, "R10", "tx held", tx_out_pkt, e1);
    tx_out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_in_valid = 1'b0;
    m_lfsr = lfsr_adv(m_lfsr);
    check(tx_out_valid && tx_out_pkt == e2, "R3", "label unchanged by stalled request", tx_out_pkt, e2);
    p1 = tx_out_pkt;

    // receive stall: a held tampered packet must not be seen until ready
    good = e1;
    bad  = p1 ^ (128'd1 << 125);
    @(negedge clk);
    rx_out_ready = 1'b0;
    rx_pkt = good; rx_in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(rx_out_valid && rx_out_payload == 96'hDEAD, "R8", "stalled rx deliver",
          128'(rx_out_payload), 128'(96'hDEAD));
    check(rx_in_ready == 1'b0, "R10", "rx_in_ready stalled", 128'(rx_in_ready), 128'(0));
    rx_pkt = bad;
    repeat (2) @(negedge clk);
    check(rx_out_valid && rx_out_payload == 96'hDEAD && !hijack_detected, "R10", "rx held",
          128'({hijack_detected, rx_out_payload}), 128'(96'hDEAD));
    rx_out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_in_valid = 1'b0;
    check(!rx_out_valid && hijack_detected, "R9", "released tampered drop",
          128'({rx_out_valid, hijack_detected}), 128'(2'b01));
    p2 = p1;
    send_rx(p2, v, h, rp, rs);
    check(v && !h && rp == 96'hBEEF && rs == 6'd7, "R8", "second stalled packet",
          128'({rs, rp}), 128'({6'd7, 96'hBEEF}));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule